// File: doc/BRIEF.md
# Line Zeros and Pulse-Density Monitor

This block sits behind the line decoder of a T1-style receiver and watches the recovered bit stream. It takes one bit per cycle in which the bit strobe is high. It reports two line-quality conditions. The first is an excessive-zeros condition: a run of zeros longer than the current line code allows. It is held in a sticky flag that software clears by reading status. The second is a pulse-density violation: ones are too sparse, either as one long zero run or as too few ones inside a sliding window. The density flag is live. It sets quickly and clears only after a long unbroken run of ones. A one-cycle interrupt pulse marks each rising edge of the density flag.

The bit input is a valid/ready stream. The monitor never applies back-pressure: `in_ready` is high in every cycle, so each cycle with `in_valid` high transfers exactly one bit. A cycle with `in_valid` low moves no bit, and every counter and the density history hold their values. The code select, the detector enable and the status-read strobe are plain level or pulse controls with no handshake.

Top module: `line_density_monitor`

## Requirements
- R1: With `code_ami` = 0 (B8ZS), `exz_flag` is 1 in the cycle after the 8th consecutive accepted zero, and is still 0 after only 7.
- R2: With `code_ami` = 1 (AMI), `exz_flag` is 1 after the 16th consecutive accepted zero, and is still 0 after only 15.
- R3: `exz_flag` holds until a cycle with `status_rd` = 1, which clears it. If an excessive-zero detection happens in that same cycle, the flag stays 1.
- R4: While `exz_en` = 0, no new excessive-zero detection is made. A flag that is already set keeps its value until it is read.
- R5: `pden_flag` becomes 1 after the 15th consecutive accepted zero, and is still 0 after 14.
- R6: `pden_flag` also sets when, for any N from 1 to 23, the last 8·(N+1) accepted bits hold fewer than N ones. A window is evaluated only once that many bits have been accepted since reset. Long runs of ones never set the flag.
- R7: Once set, `pden_flag` clears only after the 23rd consecutive accepted one. It is still 1 after 22 ones. A set condition in the same bit takes priority over the clear.
- R8: `pden_irq` is high for exactly one cycle, in the first cycle in which `pden_flag` reads 1 after being 0. It is never high otherwise.
- R9: A cycle with `in_valid` = 0 changes no run count, window or density flag, and raises no interrupt. Only `status_rd` acts in such a cycle.
- R10: After synchronous reset all flags read 0 and all history is empty. `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received bit is present on `in_bit` |
| in_ready | output | 1 | Always 1; the monitor accepts every bit |
| in_bit | input | 1 | Received line bit (1 = pulse) |
| code_ami | input | 1 | Line code: 0 = B8ZS (limit 7), 1 = AMI (limit 15) |
| exz_en | input | 1 | Enables excessive-zero detection |
| status_rd | input | 1 | Status read strobe; clears `exz_flag` |
| exz_flag | output | 1 | Sticky excessive-zeros flag |
| pden_flag | output | 1 | Live pulse-density violation flag |
| pden_irq | output | 1 | One-cycle pulse on the rising edge of `pden_flag` |

## Verification
The hardest state to reach is a density violation from the window rule alone. The stream must stay sparse enough to fail some window, yet never hold a zero run past 14. It must also run long enough to fill the relevant window. A directed pattern of a single one followed by thirteen zeros gets there: it fails the 24-bit window. Random streams at ones densities from a few percent up to ninety percent then cover the other windows, with gaps in the strobe and random reads. A bench model counts every window from scratch for every accepted bit and checks all three flags in every cycle.

// File: rtl/lzpd_pkg.sv
package lzpd_pkg;
  typedef enum logic {
    CODE_B8ZS = 1'b0,
    CODE_AMI  = 1'b1
  } line_code_e;

  function automatic int unsigned dens_window_len(int unsigned n);
    return 8 * (n + 1);
  endfunction
endpackage

// File: rtl/lzpd_run_counter.sv
module lzpd_run_counter #(
  parameter int unsigned RUN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             bit_i,
  output logic [RUN_W-1:0] zrun_next,
  output logic [RUN_W-1:0] orun_next,
  output logic [RUN_W-1:0] orun_q
);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] zrun_q;

  always_comb begin
    zrun_next = zrun_q;
    orun_next = orun_q;
    if (valid_i) begin
      if (bit_i) begin
        zrun_next = '0;
        orun_next = (orun_q == RUN_MAX) ? orun_q : orun_q + 1'b1;
      end else begin
        orun_next = '0;
        zrun_next = (zrun_q == RUN_MAX) ? zrun_q : zrun_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zrun_q <= '0;
      orun_q <= '0;
    end else begin
      zrun_q <= zrun_next;
      orun_q <= orun_next;
    end
  end

  // At most one of the two run lengths can be non-zero (R5, R7)
  assert_runs_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !((zrun_q != '0) && (orun_q != '0)));
endmodule

// File: rtl/lzpd_density.sv
module lzpd_density #(
  parameter int unsigned N_MAX = 23
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic bit_i,
  output logic fail_o
);
  import lzpd_pkg::*;

  localparam int unsigned WIN = dens_window_len(N_MAX);
  localparam int unsigned CW  = $clog2(WIN + 1);

  logic [WIN-1:0] hist_q;
  logic [CW-1:0]  fill_q, fill_next;
  logic [N_MAX-1:0] fail_vec;

  assign fill_next = (valid_i && (fill_q != CW'(WIN))) ? fill_q + 1'b1 : fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      fill_q <= fill_next;
      if (valid_i) hist_q <= {hist_q[WIN-2:0], bit_i};
    end
  end

  for (genvar g = 0; g < N_MAX; g++) begin : g_win
    localparam int unsigned NR = g + 1;
    localparam int unsigned L  = dens_window_len(NR);
    logic [CW-1:0] cnt_q, cnt_next;
    logic          drop;

    assign drop     = (fill_q >= CW'(L)) ? hist_q[L-1] : 1'b0;
    assign cnt_next = valid_i ? (cnt_q + CW'(bit_i) - CW'(drop)) : cnt_q;
    assign fail_vec[g] = valid_i && (fill_next >= CW'(L)) && (cnt_next < CW'(NR));

    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_next;
    end

    // A window count never exceeds the window length (R6)
    assert_window_count_R6: assert property (@(posedge clk) disable iff (rst)
      (cnt_q <= CW'(L)) && (cnt_q <= fill_q));
  end

  assign fail_o = |fail_vec;

  // No window is judged on a cycle without a bit (R9)
  assert_no_fail_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |-> !fail_o);
endmodule

// File: rtl/lzpd_flags.sv
module lzpd_flags #(
  parameter int unsigned RUN_W      = 6,
  parameter int unsigned B8ZS_LIMIT = 7,
  parameter int unsigned AMI_LIMIT  = 15,
  parameter int unsigned PD_ZLIMIT  = 14,
  parameter int unsigned PD_ONES    = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             bit_i,
  input  lzpd_pkg::line_code_e code_i,
  input  logic             exz_en_i,
  input  logic             rd_i,
  input  logic [RUN_W-1:0] zrun_next,
  input  logic [RUN_W-1:0] orun_next,
  input  logic             dens_fail_i,
  output logic             exz_o,
  output logic             pden_o,
  output logic             irq_o
);
  import lzpd_pkg::*;

  logic [RUN_W-1:0] exz_limit;
  logic exz_set, pd_set, pd_clr;

  assign exz_limit = (code_i == CODE_AMI) ? RUN_W'(AMI_LIMIT) : RUN_W'(B8ZS_LIMIT);
  assign exz_set   = valid_i && exz_en_i && !bit_i && (zrun_next > exz_limit);
  assign pd_set    = valid_i && ((zrun_next > RUN_W'(PD_ZLIMIT)) || dens_fail_i);
  assign pd_clr    = valid_i && (orun_next >= RUN_W'(PD_ONES));

  always_ff @(posedge clk) begin
    if (rst) begin
      exz_o  <= 1'b0;
      pden_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (exz_set)   exz_o <= 1'b1;
      else if (rd_i) exz_o <= 1'b0;
      if (pd_set)      pden_o <= 1'b1;
      else if (pd_clr) pden_o <= 1'b0;
      irq_o <= pd_set && !pden_o;
    end
  end

  assert_exz_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (exz_o && !rd_i) |=> exz_o);
  assert_exz_disabled_R4: assert property (@(posedge clk) disable iff (rst)
    (!exz_en_i && !exz_o) |=> !exz_o);
  assert_irq_edge_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pden_o && !$past(pden_o)));
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(pden_o) && !irq_o));
endmodule

// File: rtl/line_density_monitor.sv
module line_density_monitor #(
  parameter int unsigned B8ZS_LIMIT = 7,
  parameter int unsigned AMI_LIMIT  = 15,
  parameter int unsigned PD_ZLIMIT  = 14,
  parameter int unsigned PD_ONES    = 23,
  parameter int unsigned N_MAX      = 23
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic code_ami,
  input  logic exz_en,
  input  logic status_rd,
  output logic exz_flag,
  output logic pden_flag,
  output logic pden_irq
);
  import lzpd_pkg::*;

  localparam int unsigned RUN_TOP = (AMI_LIMIT > PD_ONES) ? AMI_LIMIT : PD_ONES;
  localparam int unsigned RUN_W   = $clog2(RUN_TOP + 2);

  logic [RUN_W-1:0] zrun_next, orun_next, orun_q;
  logic dens_fail;
  line_code_e code_sel;

  assign in_ready = 1'b1;
  assign code_sel = line_code_e'(code_ami);

  lzpd_run_counter #(.RUN_W(RUN_W)) u_runs (
    .clk(clk), .rst(rst), .valid_i(in_valid), .bit_i(in_bit),
    .zrun_next(zrun_next), .orun_next(orun_next), .orun_q(orun_q)
  );

  lzpd_density #(.N_MAX(N_MAX)) u_dens (
    .clk(clk), .rst(rst), .valid_i(in_valid), .bit_i(in_bit), .fail_o(dens_fail)
  );

  lzpd_flags #(
    .RUN_W(RUN_W), .B8ZS_LIMIT(B8ZS_LIMIT), .AMI_LIMIT(AMI_LIMIT),
    .PD_ZLIMIT(PD_ZLIMIT), .PD_ONES(PD_ONES)
  ) u_flags (
    .clk(clk), .rst(rst), .valid_i(in_valid), .bit_i(in_bit), .code_i(code_sel),
    .exz_en_i(exz_en), .rd_i(status_rd), .zrun_next(zrun_next),
    .orun_next(orun_next), .dens_fail_i(dens_fail),
    .exz_o(exz_flag), .pden_o(pden_flag), .irq_o(pden_irq)
  );

  // The density flag only falls at the end of a long run of ones (R7)
  assert_pden_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pden_flag) |-> (orun_q >= RUN_W'(PD_ONES)));
endmodule

// File: tb/line_density_monitor_tb.sv
module line_density_monitor_tb;
  logic clk = 1'b0;
  logic rst, in_valid, in_bit, code_ami, exz_en, status_rd;
  logic in_ready, exz_flag, pden_flag, pden_irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench reference state
  int  m_zr, m_or, m_nb;
  bit  m_exz, m_pden, m_irq;
  bit  m_hist [0:191];

  always #10 clk = ~clk;

  line_density_monitor u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .code_ami(code_ami), .exz_en(exz_en),
    .status_rd(status_rd), .exz_flag(exz_flag), .pden_flag(pden_flag),
    .pden_irq(pden_irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_zr = 0; m_or = 0; m_nb = 0;
    m_exz = 0; m_pden = 0; m_irq = 0;
    for (int i = 0; i < 192; i++) m_hist[i] = 0;
  endtask

  task automatic model_step(input bit v, input bit b, input bit rd);
    bit dfail, old_pd, eset, pset, pclr;
    int lim, ones, len;
    old_pd = m_pden;
    dfail = 0;
    if (v) begin
      if (b) begin m_zr = 0; m_or++; end
      else   begin m_or = 0; m_zr++; end
      for (int i = 191; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = b;
      if (m_nb < 192) m_nb++;
      for (int n = 1; n <= 23; n++) begin
        len = 8 * (n + 1);
        if (m_nb >= len) begin
          ones = 0;
          for (int i = 0; i < len; i++) ones += m_hist[i];
          if (ones < n) dfail = 1;
        end
      end
    end
    lim  = code_ami ? 15 : 7;
    eset = v && exz_en && !b && (m_zr > lim);
    if (eset) m_exz = 1; else if (rd) m_exz = 0;
    pset = v && ((m_zr > 14) || dfail);
    pclr = v && (m_or >= 23);
    if (pset) m_pden = 1; else if (pclr) m_pden = 0;
    m_irq = pset && !old_pd;
  endtask

  // one cycle: drive at negedge, sample 5 ns after the edge, return at negedge
  task automatic step(input bit v, input bit b, input bit rd);
    in_valid = v; in_bit = b; status_rd = rd;
    @(posedge clk); #5;
    model_step(v, b, rd);
    chk("R1 R2 R3 R4 exz_flag vs model", exz_flag, m_exz);
    chk("R5 R6 R7 R9 pden_flag vs model", pden_flag, m_pden);
    chk("R8 pden_irq vs model", pden_irq, m_irq);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_bit = 0; status_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic run_zeros(input int k);
    for (int i = 0; i < k; i++) step(1, 0, 0);
  endtask

  task automatic run_ones(input int k);
    for (int i = 0; i < k; i++) step(1, 1, 0);
  endtask

  initial begin
    code_ami = 0; exz_en = 1;
    do_reset();
    // R10: reset state
    chk("R10 reset exz_flag", exz_flag, 0);
    chk("R10 reset pden_flag", pden_flag, 0);
    chk("R10 reset pden_irq", pden_irq, 0);
    chk("R10 in_ready", in_ready, 1);

    // R1: B8ZS limit
    run_zeros(7);  chk("R1 after 7 zeros", exz_flag, 0);
    run_zeros(1);  chk("R1 after 8 zeros", exz_flag, 1);
    // R3: read with simultaneous detection keeps flag, plain read clears
    step(1, 0, 1); chk("R3 read with detection", exz_flag, 1);
    step(0, 0, 1); chk("R3 read clears", exz_flag, 0);
    step(1, 1, 0);

    // R2: AMI limit
    do_reset(); code_ami = 1;
    run_zeros(15); chk("R2 after 15 zeros", exz_flag, 0);
    run_zeros(1);  chk("R2 after 16 zeros", exz_flag, 1);
    step(0, 0, 1); chk("R3 read clears AMI", exz_flag, 0);

    // R4: enable low blocks detection, set flag survives
    do_reset(); code_ami = 0; exz_en = 0;
    run_zeros(20); chk("R4 disabled no detection", exz_flag, 0);
    exz_en = 1; step(1, 0, 0); chk("R4 enabled detects", exz_flag, 1);
    exz_en = 0; run_zeros(3); chk("R4 disabled keeps set flag", exz_flag, 1);
    step(0, 0, 1); chk("R4 cleared by read", exz_flag, 0);
    exz_en = 1;

    // R5, R8, R7: zero-run violation, interrupt, clear by ones
    do_reset();
    run_zeros(14); chk("R5 after 14 zeros", pden_flag, 0);
    run_zeros(1);  chk("R5 after 15 zeros", pden_flag, 1);
    chk("R8 irq on rise", pden_irq, 1);
    run_zeros(1);  chk("R8 irq one cycle", pden_irq, 0);
    run_ones(22);  chk("R7 22 ones keep flag", pden_flag, 1);
    run_ones(1);   chk("R7 23rd one clears", pden_flag, 0);
    chk("R8 no irq on fall", pden_irq, 0);

    // R9: idle cycles hold the zero run
    do_reset();
    run_zeros(14);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    chk("R9 idle cycles hold", pden_flag, 0);
    step(1, 0, 0); chk("R9 run resumes after idle", pden_flag, 1);

    // R6: dense ones never violate; sparse pattern violates by window only
    do_reset();
    run_ones(200); chk("R6 all ones no violation", pden_flag, 0);
    do_reset();
    for (int r = 0; r < 4; r++) begin
      step(1, 1, 0);
      run_zeros(13);
    end
    chk("R6 window rule sets flag", pden_flag, 1);

    // sweep: densities, codes, enables, gaps and reads
    for (int cfg = 0; cfg < 20; cfg++) begin
      int pct;
      do_reset();
      code_ami = cfg[0];
      exz_en   = (cfg % 5) != 4;
      pct = (cfg % 5 == 0) ? 4 : (cfg % 5 == 1) ? 9 : (cfg % 5 == 2) ? 20 :
            (cfg % 5 == 3) ? 50 : 90;
      for (int i = 0; i < 1500; i++) begin
        bit v, b, rd;
        if (i % 300 == 0 && pct > 9) pct = (pct == 90) ? 12 : pct + 15;
        v  = ($urandom % 100) < 85;
        b  = ($urandom % 100) < pct;
        rd = ($urandom % 100) < 4;
        step(v, b, rd);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule